// File: doc/BRIEF.md
# Iterative Integer Divider with Precise Exception Detection

This block divides a 32-bit dividend by a 32-bit divisor over several clock cycles, in either unsigned or two's-complement signed mode. A one-cycle start pulse presents the operands, a mode select and the address of the divide instruction. If the operation is legal, the block runs a radix-2 restoring loop on operand magnitudes for one cycle per quotient bit, then corrects the quotient sign and raises a one-cycle done pulse. The done pulse also serves as the write strobe for the register file.

Before any iteration starts, the block screens the operands. A zero divisor in either mode, or the single signed case that cannot be represented (most negative value divided by minus one), skips the loop. Instead the block raises an exception pulse with a cause code and the faulting instruction address, for the processor's exception entry logic. No done pulse follows, so nothing is written back. While a division is in progress, busy is high and new start pulses are ignored.

Top module: `int_div`

## Requirements
- R1: While reset is held and after it is released, busy_o, done_o and exc_o are low, exc_cause_o is 2'b00 and quot_o is zero.
- R2: In unsigned mode (signed_i = 0) with a non-zero divisor, quot_o after the done pulse equals floor(dividend / divisor), and done_o is high for exactly one cycle.
- R3: In signed mode (signed_i = 1), the quotient is truncated toward zero. Its sign is negative exactly when the operand signs differ and the magnitude is non-zero.
- R4: A divisor of zero, in either mode, raises exc_o with exc_cause_o = 2'b01, and done_o is not pulsed for that operation.
- R5: In signed mode, dividend 0x80000000 with divisor 0xFFFFFFFF raises exc_o with exc_cause_o = 2'b10, and done_o is not pulsed.
- R6: In unsigned mode, no non-zero divisor raises an exception. In particular, 0xFFFFFFFF / 1 gives 0xFFFFFFFF and 0x80000000 / 0xFFFFFFFF gives 0.
- R7: When exc_o is high, exc_pc_o holds the pc_i value presented with the start pulse that caused the exception.
- R8: exc_o goes high right after the clock edge that accepts the faulting start and has busy_o low. For a legal operation, busy_o is high right after the accepting edge, and done_o goes high exactly WIDTH edges after the accepting edge, with busy_o falling at the same edge.
- R9: A start pulse while busy_o is high is ignored and does not change the running operation's result or timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted when busy_o is low |
| signed_i | input | 1 | 1 selects signed division, 0 selects unsigned |
| dividend_i | input | WIDTH | Dividend |
| divisor_i | input | WIDTH | Divisor |
| pc_i | input | WIDTH | Address of the divide instruction |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle result valid and write strobe |
| quot_o | output | WIDTH | Quotient, valid from done_o onward |
| exc_o | output | 1 | One-cycle exception request |
| exc_cause_o | output | 2 | 01 divide by zero, 10 signed overflow |
| exc_pc_o | output | WIDTH | Faulting instruction address |

## Verification
The bench builds the block with its default WIDTH of 32. This makes the exact corner values checkable: the 0x80000000 by 0xFFFFFFFF pair in both modes, and all-ones dividends. It also makes the 32-edge loop latency directly countable against the exception path, which responds at the accepting edge. A start pulse issued partway through a division, carrying a zero divisor, confirms that the busy interlock drops it without an exception and without disturbing the result.

// File: rtl/int_div_pkg.sv
package int_div_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_ZERO = 2'b01,
    CAUSE_OVF  = 2'b10
  } div_cause_e;
endpackage

// File: rtl/div_check.sv
// Operand screening and magnitude extraction, purely combinational.
module div_check #(
  parameter int WIDTH = 32
) (
  input  logic             signed_i,
  input  logic [WIDTH-1:0] dividend_i,
  input  logic [WIDTH-1:0] divisor_i,
  output logic             zero_o,
  output logic             ovf_o,
  output logic             neg_o,
  output logic [WIDTH-1:0] num_mag_o,
  output logic [WIDTH-1:0] den_mag_o
);
  localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};
  localparam logic [WIDTH-1:0] ALL_ONES = '1;

  logic num_neg, den_neg;

  always_comb begin
    num_neg   = signed_i & dividend_i[WIDTH-1];
    den_neg   = signed_i & divisor_i[WIDTH-1];
    zero_o    = (divisor_i == '0);
    ovf_o     = signed_i && (dividend_i == MOST_NEG) && (divisor_i == ALL_ONES);
    neg_o     = num_neg ^ den_neg;
    num_mag_o = num_neg ? (~dividend_i + 1'b1) : dividend_i;
    den_mag_o = den_neg ? (~divisor_i + 1'b1) : divisor_i;
  end
endmodule

// File: rtl/div_core.sv
// Radix-2 restoring loop on magnitudes, sign fix applied on the last step.
module div_core #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             neg_i,
  input  logic [WIDTH-1:0] num_i,
  input  logic [WIDTH-1:0] den_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] quot_o
);
  localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

  logic             busy_q, done_q, neg_q;
  logic [CNT_W-1:0] cnt_q;
  logic [WIDTH-1:0] rem_q, q_q, den_q, quot_q;

  logic [WIDTH:0]   shifted, diff;
  logic             take;
  logic [WIDTH-1:0] rem_n, q_n;

  always_comb begin
    shifted = {rem_q, q_q[WIDTH-1]};
    diff    = shifted - {1'b0, den_q};
    take    = ~diff[WIDTH];
    rem_n   = take ? diff[WIDTH-1:0] : shifted[WIDTH-1:0];
    q_n     = {q_q[WIDTH-2:0], take};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      neg_q  <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      q_q    <= '0;
      den_q  <= '0;
      quot_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (load_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        rem_q  <= '0;
        q_q    <= num_i;
        den_q  <= den_i;
        neg_q  <= neg_i;
      end else if (busy_q) begin
        rem_q <= rem_n;
        q_q   <= q_n;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          quot_q <= neg_q ? (~q_n + 1'b1) : q_n;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign quot_o = quot_q;
endmodule

// File: rtl/int_div.sv
module int_div
  import int_div_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             signed_i,
  input  logic [WIDTH-1:0] dividend_i,
  input  logic [WIDTH-1:0] divisor_i,
  input  logic [WIDTH-1:0] pc_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] quot_o,
  output logic             exc_o,
  output logic [1:0]       exc_cause_o,
  output logic [WIDTH-1:0] exc_pc_o
);
  logic             zero, ovf, neg, accept, fault, load;
  logic [WIDTH-1:0] num_mag, den_mag;
  logic             exc_q;
  div_cause_e       cause_q;
  logic [WIDTH-1:0] pc_q;

  div_check #(.WIDTH(WIDTH)) u_check (
    .signed_i  (signed_i),
    .dividend_i(dividend_i),
    .divisor_i (divisor_i),
    .zero_o    (zero),
    .ovf_o     (ovf),
    .neg_o     (neg),
    .num_mag_o (num_mag),
    .den_mag_o (den_mag)
  );

  assign accept = start_i & ~busy_o;
  assign fault  = accept & (zero | ovf);
  assign load   = accept & ~fault;

  div_core #(.WIDTH(WIDTH)) u_core (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .neg_i (neg),
    .num_i (num_mag),
    .den_i (den_mag),
    .busy_o(busy_o),
    .done_o(done_o),
    .quot_o(quot_o)
  );

  // Exception response registered at the accepting edge; loop never starts.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exc_q   <= 1'b0;
      cause_q <= CAUSE_NONE;
      pc_q    <= '0;
    end else begin
      exc_q <= fault;
      if (fault) begin
        cause_q <= zero ? CAUSE_ZERO : CAUSE_OVF;
        pc_q    <= pc_i;
      end
    end
  end

  assign exc_o       = exc_q;
  assign exc_cause_o = exc_q ? cause_q : CAUSE_NONE;
  assign exc_pc_o    = pc_q;
endmodule

// File: rtl/int_div_chk.sv
module int_div_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             signed_i,
  input logic [WIDTH-1:0] dividend_i,
  input logic [WIDTH-1:0] divisor_i,
  input logic [WIDTH-1:0] pc_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             exc_o,
  input logic [1:0]       exc_cause_o,
  input logic [WIDTH-1:0] exc_pc_o
);
  localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};

  AST_DONE_EXC_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && exc_o)); // R4

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R2

  AST_DIV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && divisor_i == '0) |=> (exc_o && exc_cause_o == 2'b01 && !busy_o)); // R4

  AST_SIGNED_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && signed_i && dividend_i == MOST_NEG && divisor_i == '1)
      |=> (exc_o && exc_cause_o == 2'b10)); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !signed_i && divisor_i != '0) |=> (!exc_o && busy_o)); // R6

  AST_EXC_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && divisor_i == '0) |=> (exc_pc_o == $past(pc_i))); // R7

  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !$past(busy_o) && !done_o) |-> $past(start_i)); // R8

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o))); // R8

  AST_BUSY_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_o) |=> !exc_o); // R9
endmodule

bind int_div int_div_chk #(.WIDTH(WIDTH)) u_int_div_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .signed_i   (signed_i),
  .dividend_i (dividend_i),
  .divisor_i  (divisor_i),
  .pc_i       (pc_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .exc_o      (exc_o),
  .exc_cause_o(exc_cause_o),
  .exc_pc_o   (exc_pc_o)
);

// File: tb/tb_int_div.sv
`timescale 1ns/1ps
module tb_int_div;
  localparam int W = 32;
  localparam int N = 14;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic         signed_i = 1'b0;
  logic [W-1:0] dividend_i = '0;
  logic [W-1:0] divisor_i = '0;
  logic [W-1:0] pc_i = '0;
  logic         busy_o, done_o, exc_o;
  logic [W-1:0] quot_o, exc_pc_o;
  logic [1:0]   exc_cause_o;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  int_div #(.WIDTH(W)) dut (.*);

  // mode, dividend, divisor, expected quotient, expected cause (0 none, 1 zero, 2 overflow)
  localparam logic         V_S [N] = '{0, 0, 0, 1, 1, 1, 1, 1, 0, 1, 1, 0, 1, 0};
  localparam logic [W-1:0] V_A [N] = '{32'd100, 32'hFFFFFFFF, 32'h80000000, 32'hFFFFFFF9,
                                      32'd7, 32'hFFFFFFF9, 32'h80000000, 32'h80000000,
                                      32'd5, 32'h80000000, 32'd0, 32'd3, 32'h80000000,
                                      32'hFFFFFFFF};
  localparam logic [W-1:0] V_B [N] = '{32'd7, 32'd1, 32'hFFFFFFFF, 32'd2,
                                      32'hFFFFFFFE, 32'hFFFFFFFE, 32'd1, 32'd2,
                                      32'd0, 32'hFFFFFFFF, 32'd0, 32'd5, 32'h80000000,
                                      32'h00010000};
  localparam logic [W-1:0] V_Q [N] = '{32'd14, 32'hFFFFFFFF, 32'd0, 32'hFFFFFFFD,
                                      32'hFFFFFFFD, 32'd3, 32'h80000000, 32'hC0000000,
                                      32'd0, 32'd0, 32'd0, 32'd0, 32'd1, 32'h0000FFFF};
  localparam logic [1:0]   V_C [N] = '{0, 0, 0, 0, 0, 0, 0, 0, 1, 2, 1, 0, 0, 0};

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drives one start pulse; returns edges after the accepting edge until a response.
  task automatic run_op(input logic s, input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [W-1:0] pc, input logic [W-1:0] eq,
                        input logic [1:0] ec, input string req);
    int lat;
    bit resp_exc, resp_done;
    @(negedge clk_i);
    start_i = 1'b1; signed_i = s; dividend_i = a; divisor_i = b; pc_i = pc;
    @(posedge clk_i); #1;
    start_i = 1'b0;
    lat = 0;
    if (ec == 0) check(busy_o === 1'b1, {req, " R8 busy"}, W'(busy_o), 1);
    while (!(exc_o || done_o) && lat < 100) begin
      @(posedge clk_i); #1;
      lat++;
    end
    resp_exc = exc_o; resp_done = done_o;
    if (ec != 0) begin
      check(resp_exc && !resp_done, {req, " R4/R5 exc"}, W'({resp_exc, resp_done}), 2);
      check(exc_cause_o == ec, {req, " R4/R5 cause"}, W'(exc_cause_o), W'(ec));
      check(exc_pc_o == pc, {req, " R7 pc"}, exc_pc_o, pc);
      check(lat == 0 && !busy_o, {req, " R8 exc latency"}, W'(lat), 0);
      @(posedge clk_i); #1;
      check(!done_o && !exc_o, {req, " R4 no writeback"}, W'({exc_o, done_o}), 0);
    end else begin
      check(resp_done && !resp_exc, {req, " R6 no exc"}, W'({resp_exc, resp_done}), 1);
      check(quot_o == eq, {req, " R2/R3 quot"}, quot_o, eq);
      check(lat == W && !busy_o, {req, " R8 done latency"}, W'(lat), W);
      @(posedge clk_i); #1;
      check(!done_o, {req, " R2 done one cycle"}, W'(done_o), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    check(!busy_o && !done_o && !exc_o && exc_cause_o == 2'b00 && quot_o == '0,
          "R1 in reset", quot_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(posedge clk_i); #1;
    check(!busy_o && !done_o && !exc_o && quot_o == '0, "R1 after reset", quot_o, 0);

    for (int i = 0; i < N; i++)
      run_op(V_S[i], V_A[i], V_B[i], 32'h1000 + W'(i * 2), V_Q[i], V_C[i],
             $sformatf("vec%0d", i));

    // R9: a faulting start issued mid-operation is dropped
    begin
      int lat;
      @(negedge clk_i);
      start_i = 1'b1; signed_i = 1'b0; dividend_i = 32'd1000; divisor_i = 32'd10;
      pc_i = 32'h2000;
      @(posedge clk_i); #1;
      start_i = 1'b0;
      lat = 0;
      repeat (4) begin @(posedge clk_i); #1; lat++; end
      @(negedge clk_i);
      start_i = 1'b1; dividend_i = 32'd7; divisor_i = 32'd0; pc_i = 32'h3000;
      @(posedge clk_i); #1; lat++;
      start_i = 1'b0;
      check(!exc_o && busy_o, "R9 start ignored while busy", W'(exc_o), 0);
      while (!(exc_o || done_o) && lat < 100) begin
        @(posedge clk_i); #1; lat++;
      end
      check(done_o && !exc_o && quot_o == 32'd100, "R9 result intact", quot_o, 100);
      check(lat == W, "R9 latency intact", W'(lat), W);
    end

    // R3: zero dividend in signed mode with negative divisor gives +0
    run_op(1'b1, 32'd0, 32'hFFFFFFFB, 32'h4000, 32'd0, 2'd0, "R3 zero dividend");
    // R6: unsigned all-ones by all-ones
    run_op(1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h4004, 32'd1, 2'd0, "R6 max by max");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule